// File: doc/BRIEF.md
# Serial Display-Bus Driver Sequencer

This block sits on the host side of a display that is wired behind a chain of latched serial-in, parallel-out shift registers. A client presents one display word plus a register-select bit over a valid/ready handshake. The block then shifts the word out one bit at a time. For each bit it places the bit on the serial data line and then pulses the shift clock. Once every bit is in the chain, it strobes the latch clock once so that all register outputs update together. It then drives the register-select line and pulses the display enable line.

Register select and enable go straight to the display and are never part of the shifted word. The most significant bit leaves first, so in a chain of registers the bits for the device farthest from the host go out first. The word width and every pulse width and delay are set by parameters in system-clock cycles. The output-enable line of the register chain is held active (low).

Top module: `disp_ser_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, word_ready_o is 1 and sh_clk_o, lat_clk_o, en_o, busy_o and done_o are 0.
- R2: A word is taken on the clock edge where word_valid_i and word_ready_o are both 1. word_ready_o is 0 from the next cycle until the enable pulse has ended. busy_o is always the inverse of word_ready_o.
- R3: Each transfer makes exactly WORD_W rising edges on sh_clk_o. At the k-th rising edge (k from 0), ser_data_o equals word bit WORD_W-1-k, so the most significant bit goes first and reaches the farthest chained device.
- R4: ser_data_o changes only while sh_clk_o is low. It is stable for at least SETUP_CYC cycles before each sh_clk_o rising edge, and it holds through the high phase and the following low phase.
- R5: Each sh_clk_o pulse is high for exactly SHIFT_HI_CYC cycles. Between pulses it is low for at least SHIFT_LO_CYC cycles, and it idles low.
- R6: lat_clk_o pulses exactly once per transfer, for exactly LATCH_CYC cycles, and only after the last sh_clk_o pulse has ended.
- R7: en_o pulses exactly once per transfer, for exactly EN_CYC cycles, and only after the latch pulse has ended. During the pulse, rs_o equals the select bit taken with the word and does not change.
- R8: out_en_no is 0 at all times.
- R9: done_o is high for one cycle, in the cycle right after en_o falls, once per transfer. busy_o stays high for WORD_W*(SETUP_CYC+SHIFT_HI_CYC+SHIFT_LO_CYC)+LATCH_CYC+SETUP_CYC+EN_CYC cycles.
- R10: word_valid_i has no effect while word_ready_o is 0. No second transfer starts, and the word already in flight is sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | Client offers a word |
| word_data_i | input | WORD_W | Display word to shift out |
| word_rs_i | input | 1 | Register-select value for this word |
| word_ready_o | output | 1 | Block can take a word |
| ser_data_o | output | 1 | Serial data to the first register |
| sh_clk_o | output | 1 | Shift clock to the chain |
| lat_clk_o | output | 1 | Latch clock to the chain |
| out_en_no | output | 1 | Chain output enable, active low |
| rs_o | output | 1 | Display register select |
| en_o | output | 1 | Display enable strobe |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions check several properties on every cycle:
- the output enable is held low;
- ready and busy are complementary;
- ready drops after an accepted word;
- the serial data holds while the shift clock is high;
- the shift clock, the latch and the enable never overlap;
- register select is steady during enable;
- done is a single pulse that follows enable.

Other properties need the bench's scenarios:
- the bit order and value of each shifted word;
- the exact pulse counts and widths;
- the setup run before each shift edge;
- the latch coming only after the last shift;
- the total transfer length;
- that an offer made while busy is ignored.

The bench covers these over every 8-bit data value.

// File: rtl/disp_ser_pkg.sv
package disp_ser_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHHI,
    ST_SHLO,
    ST_LATCH,
    ST_RSSET,
    ST_ENHI
  } seq_state_e;

  function automatic int unsigned max_of5(int unsigned a, int unsigned b, int unsigned c,
                                          int unsigned d, int unsigned e);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/disp_ser_timer.sv
module disp_ser_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/disp_ser_shreg.sv
module disp_ser_shreg #(
  parameter int unsigned WORD_W = 8,
  localparam int unsigned BIT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              shift_i,
  output logic              msb_o,
  output logic              last_o
);
  logic [WORD_W-1:0] sr_q;
  logic [BIT_W-1:0]  left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sr_q   <= data_i;
      left_q <= BIT_W'(WORD_W);
    end else if (shift_i) begin
      sr_q   <= {sr_q[WORD_W-2:0], 1'b0};
      if (left_q != '0) left_q <= left_q - 1'b1;
    end
  end

  assign msb_o  = sr_q[WORD_W-1];
  assign last_o = (left_q == BIT_W'(1));
endmodule

// File: rtl/disp_ser_ctrl.sv
module disp_ser_ctrl
  import disp_ser_pkg::*;
#(
  parameter int unsigned SETUP_CYC    = 1,
  parameter int unsigned SHIFT_HI_CYC = 2,
  parameter int unsigned SHIFT_LO_CYC = 1,
  parameter int unsigned LATCH_CYC    = 2,
  parameter int unsigned EN_CYC       = 3,
  parameter int unsigned CNT_W        = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             tmr_zero_i,
  input  logic             last_bit_i,
  output seq_state_e       state_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             sr_load_o,
  output logic             sr_shift_o,
  output logic             rs_load_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] D_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] D_HI    = CNT_W'(SHIFT_HI_CYC - 1);
  localparam logic [CNT_W-1:0] D_LO    = CNT_W'(SHIFT_LO_CYC - 1);
  localparam logic [CNT_W-1:0] D_LAT   = CNT_W'(LATCH_CYC - 1);
  localparam logic [CNT_W-1:0] D_EN    = CNT_W'(EN_CYC - 1);

  seq_state_e state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    sr_load_o  = 1'b0;
    sr_shift_o = 1'b0;
    rs_load_o  = 1'b0;
    done_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (valid_i) begin
        state_d    = ST_SETUP;
        tmr_load_o = 1'b1;
        tmr_val_o  = D_SETUP;
        sr_load_o  = 1'b1;
      end
      ST_SETUP: if (tmr_zero_i) begin
        state_d    = ST_SHHI;
        tmr_load_o = 1'b1;
        tmr_val_o  = D_HI;
      end
      ST_SHHI: if (tmr_zero_i) begin
        state_d    = ST_SHLO;
        tmr_load_o = 1'b1;
        tmr_val_o  = D_LO;
      end
      ST_SHLO: if (tmr_zero_i) begin
        tmr_load_o = 1'b1;
        if (last_bit_i) begin
          state_d   = ST_LATCH;
          tmr_val_o = D_LAT;
        end else begin
          state_d    = ST_SETUP;
          tmr_val_o  = D_SETUP;
          sr_shift_o = 1'b1;  // next bit appears while clock is low
        end
      end
      ST_LATCH: if (tmr_zero_i) begin
        state_d    = ST_RSSET;
        tmr_load_o = 1'b1;
        tmr_val_o  = D_SETUP;
        rs_load_o  = 1'b1;
      end
      ST_RSSET: if (tmr_zero_i) begin
        state_d    = ST_ENHI;
        tmr_load_o = 1'b1;
        tmr_val_o  = D_EN;
      end
      ST_ENHI: if (tmr_zero_i) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;
endmodule

// File: rtl/disp_ser_seq.sv
module disp_ser_seq
  import disp_ser_pkg::*;
#(
  parameter int unsigned WORD_W       = 8,
  parameter int unsigned SETUP_CYC    = 1,
  parameter int unsigned SHIFT_HI_CYC = 2,
  parameter int unsigned SHIFT_LO_CYC = 1,
  parameter int unsigned LATCH_CYC    = 2,
  parameter int unsigned EN_CYC       = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_data_i,
  input  logic              word_rs_i,
  output logic              word_ready_o,
  output logic              ser_data_o,
  output logic              sh_clk_o,
  output logic              lat_clk_o,
  output logic              out_en_no,
  output logic              rs_o,
  output logic              en_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned MAX_CYC =
    max_of5(SETUP_CYC, SHIFT_HI_CYC, SHIFT_LO_CYC, LATCH_CYC, EN_CYC);
  localparam int unsigned CNT_W = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  seq_state_e       state;
  logic             tmr_load, tmr_zero, sr_load, sr_shift, rs_load, last_bit;
  logic [CNT_W-1:0] tmr_val;
  logic             rs_hold_q, rs_q;

  disp_ser_ctrl #(
    .SETUP_CYC   (SETUP_CYC),
    .SHIFT_HI_CYC(SHIFT_HI_CYC),
    .SHIFT_LO_CYC(SHIFT_LO_CYC),
    .LATCH_CYC   (LATCH_CYC),
    .EN_CYC      (EN_CYC),
    .CNT_W       (CNT_W)
  ) ctrl_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (word_valid_i),
    .tmr_zero_i(tmr_zero),
    .last_bit_i(last_bit),
    .state_o   (state),
    .tmr_load_o(tmr_load),
    .tmr_val_o (tmr_val),
    .sr_load_o (sr_load),
    .sr_shift_o(sr_shift),
    .rs_load_o (rs_load),
    .done_o    (done_o)
  );

  disp_ser_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  disp_ser_shreg #(.WORD_W(WORD_W)) sr_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (sr_load),
    .data_i (word_data_i),
    .shift_i(sr_shift),
    .msb_o  (ser_data_o),
    .last_o (last_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs_hold_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      if (sr_load) rs_hold_q <= word_rs_i;
      if (rs_load) rs_q      <= rs_hold_q;
    end
  end

  assign word_ready_o = (state == ST_IDLE);
  assign busy_o       = ~word_ready_o;
  assign sh_clk_o     = (state == ST_SHHI);
  assign lat_clk_o    = (state == ST_LATCH);
  assign en_o         = (state == ST_ENHI);
  assign rs_o         = rs_q;
  assign out_en_no    = 1'b0;
endmodule

// File: rtl/disp_ser_seq_chk.sv
module disp_ser_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic word_valid_i,
  input logic word_ready_o,
  input logic ser_data_o,
  input logic sh_clk_o,
  input logic lat_clk_o,
  input logic out_en_no,
  input logic rs_o,
  input logic en_o,
  input logic busy_o,
  input logic done_o
);
  AST_OE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_no); // R8
  AST_READY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_ready_o != busy_o); // R2
  AST_READY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && word_ready_o) |=> !word_ready_o); // R2
  AST_SER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_clk_o && $past(sh_clk_o)) |-> $stable(ser_data_o)); // R4
  AST_LAT_NO_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_clk_o |-> !sh_clk_o); // R6
  AST_EN_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> !(lat_clk_o || sh_clk_o)); // R7
  AST_RS_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && $past(en_o)) |-> $stable(rs_o)); // R7
  AST_DONE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_AFTER_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(en_o) && !en_o)); // R9
endmodule

bind disp_ser_seq disp_ser_seq_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .word_valid_i(word_valid_i),
  .word_ready_o(word_ready_o),
  .ser_data_o  (ser_data_o),
  .sh_clk_o    (sh_clk_o),
  .lat_clk_o   (lat_clk_o),
  .out_en_no   (out_en_no),
  .rs_o        (rs_o),
  .en_o        (en_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/disp_ser_seq_tb_top.sv
`timescale 1ns/1ps
module disp_ser_seq_tb_top;
  localparam int W = 8, SU = 1, HI = 2, LO = 1, LT = 2, EN = 3;
  localparam int XFER = W * (SU + HI + LO) + LT + SU + EN;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vld = 1'b0, rs_in = 1'b0;
  logic [W-1:0] dat = '0;
  logic rdy, ser, sck, lat, oe_n, rs, en, busy, done;

  always #2.5 clk = ~clk;

  disp_ser_seq #(.WORD_W(W), .SETUP_CYC(SU), .SHIFT_HI_CYC(HI), .SHIFT_LO_CYC(LO),
                 .LATCH_CYC(LT), .EN_CYC(EN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .word_valid_i(vld), .word_data_i(dat), .word_rs_i(rs_in),
    .word_ready_o(rdy), .ser_data_o(ser), .sh_clk_o(sck), .lat_clk_o(lat),
    .out_en_no(oe_n), .rs_o(rs), .en_o(en), .busy_o(busy), .done_o(done));

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-transfer monitor state
  logic [W-1:0] rx;
  int sck_cnt, lat_cnt, en_cnt, done_cnt, busy_cyc;
  int setup_err, hi_err, lo_err, lat_err, en_err, oe_err, rdy_err, rs_at_en, rs_err;
  int run_stable, hi_len, lo_len, lat_len, en_len;
  logic p_sck = 0, p_lat = 0, p_en = 0, p_ser = 0, p_rs = 0;

  task automatic clr();
    rx = '0; sck_cnt = 0; lat_cnt = 0; en_cnt = 0; done_cnt = 0; busy_cyc = 0;
    setup_err = 0; hi_err = 0; lo_err = 0; lat_err = 0; en_err = 0; oe_err = 0;
    rdy_err = 0; rs_at_en = -1; rs_err = 0; lo_len = 0;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (oe_n !== 1'b0) oe_err++;
    if (rdy === busy) rdy_err++;
    if (busy) busy_cyc++;
    if (done) done_cnt++;
    // shift clock
    if (sck && !p_sck) begin
      if (ser !== p_ser || run_stable < SU) setup_err++;
      if (sck_cnt > 0 && lo_len < LO) lo_err++;
      if (lat_cnt > 0) lat_err++;
      rx = {rx[W-2:0], ser};
      sck_cnt++;
      hi_len = 1;
    end else if (sck) hi_len++;
    if (!sck && p_sck) begin
      if (hi_len != HI) hi_err++;
      lo_len = 0;
    end
    if (!sck) lo_len++;
    if (ser !== p_ser) begin
      if (sck || p_sck) setup_err++;
      run_stable = 1;
    end else run_stable++;
    // latch
    if (lat && !p_lat) begin
      lat_cnt++; lat_len = 1;
      if (sck_cnt != W || sck) lat_err++;
    end else if (lat) lat_len++;
    if (!lat && p_lat && lat_len != LT) lat_err++;
    // enable
    if (en && !p_en) begin
      en_cnt++; en_len = 1; rs_at_en = rs;
      if (lat_cnt == 0 || lat) en_err++;
    end else if (en) begin
      en_len++;
      if (rs !== p_rs) rs_err++;
    end
    if (!en && p_en && en_len != EN) en_err++;
    p_sck = sck; p_lat = lat; p_en = en; p_ser = ser; p_rs = rs;
  end

  task automatic wait_done();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk); #1;
      if (done_cnt > 0) break;
    end
  endtask

  task automatic xfer(input logic [W-1:0] d, input logic r, input bit hold_busy, input logic [W-1:0] junk);
    @(negedge clk); #1;
    clr();
    dat = d; rs_in = r; vld = 1'b1;
    @(negedge clk); #1;
    if (hold_busy) begin
      dat = junk; rs_in = ~r;  // R10: offered while not ready
    end else vld = 1'b0;
    wait_done();
    vld = 1'b0;
    chk(rx == d, "R3", "shifted word", rx, d);
    chk(sck_cnt == W, "R3", "shift pulses", sck_cnt, W);
    chk(setup_err == 0, "R4", "setup/hold errors", setup_err, 0);
    chk(hi_err == 0 && lo_err == 0, "R5", "shift clock width errors", hi_err + lo_err, 0);
    chk(lat_cnt == 1 && lat_err == 0, "R6", "latch pulses", lat_cnt, 1);
    chk(en_cnt == 1 && en_err == 0, "R7", "enable pulses", en_cnt, 1);
    chk(rs_at_en == int'(r) && rs_err == 0, "R7", "select during enable", rs_at_en, r);
    chk(oe_err == 0, "R8", "output enable high cycles", oe_err, 0);
    chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
    chk(busy_cyc == XFER, "R9", "busy cycles", busy_cyc, XFER);
    chk(rdy_err == 0 && rdy === 1'b1, "R2", "ready/busy", rdy_err, 0);
  endtask

  initial begin
    #1;
    chk(rdy === 1 && sck === 0 && lat === 0 && en === 0 && busy === 0 && done === 0,
        "R1", "in-reset outputs", {rdy, sck, lat, en, busy, done}, 6'b100000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy === 1 && sck === 0 && lat === 0 && en === 0 && busy === 0 && done === 0,
        "R1", "post-reset outputs", {rdy, sck, lat, en, busy, done}, 6'b100000);
    chk(oe_n === 1'b0, "R8", "output enable after reset", oe_n, 0);
    clr(); run_stable = 100;
    for (int v = 0; v < (1 << W); v++)
      xfer(W'(v), v[0] ^ v[W-1], 1'b0, '0);
    // R10: valid held with another word during the whole transfer
    xfer(8'hA5, 1'b1, 1'b1, 8'h3C);
    xfer(8'h00, 1'b0, 1'b1, 8'hFF);
    clr();
    repeat (40) @(negedge clk);
    #1;
    chk(sck_cnt == 0 && busy_cyc == 0, "R10", "activity after ignored offer", sck_cnt + busy_cyc, 0);
    chk(sck === 1'b0 && rdy === 1'b1, "R5", "idle shift clock low", sck, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    tests++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule